// File: doc/BRIEF.md
# Lock Window Boost Controller

This block helps a frequency synthesizer loop reach lock quickly after it starts. It watches the feedback divider and opens a lock window centred on each falling edge of the divided feedback signal. The window is active low and lasts 2*HALF input-clock periods. While the block is armed, every phase-detector correction pulse drives a separate boost output toward the side the correction asks for. That output pushes extra charge into the loop filter.

The first correction pulse that both starts and ends inside an open window disarms the block, and the boost output then floats. The block stays disarmed after that, even if later pulses fall outside the window. Only a pass through standby, with the run enable dropped and raised again, arms it once more. The three-state boost pin is split into a drive-enable and a drive-value pair. The pad cell combines them into the pin.

Top module: `lock_boost_ctrl`

## Requirements
- R1: When `cnt_rem_i` equals HALF (32) in a cycle with `run_i` high, `win_no` is low from the next cycle.
- R2: An FV falling edge is `fv_i` low in a cycle after a cycle with it high. The window returns high HALF cycles after the cycle of that edge. With the edge arriving HALF cycles after the opening match, `win_no` is low for exactly 2*HALF cycles.
- R3: While armed and running, `up_i` high with `dn_i` low gives `boost_en_o`=1 and `boost_val_o`=1.
- R4: While armed and running, `dn_i` high with `up_i` low gives `boost_en_o`=1 and `boost_val_o`=0.
- R5: A correction pulse that rises while `win_no` is high leaves the block armed, even if the pulse ends inside the window.
- R6: A correction pulse (`up_i` or `dn_i`) that rises and falls with `win_no` low disarms the block from the cycle after its fall. A pulse that is still high when the window closes does not disarm it.
- R7: Once disarmed, the block stays disarmed while `run_i` stays high. Later pulses, inside or outside the window, leave `boost_en_o` at 0.
- R8: With `run_i` low, `boost_en_o` is 0 and `win_no` is high from the next cycle. The low cycle re-arms the block, so boosting resumes once `run_i` is high again.
- R9: After reset, `win_no` is 1, `boost_en_o` is 0 and the block is armed.
- R10: With `up_i` and `dn_i` both high, `boost_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input (VCO) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable; low means standby |
| fv_i | input | 1 | Divided feedback signal |
| cnt_rem_i | input | CNT_W | Divider count remaining |
| up_i | input | 1 | Phase detector up correction |
| dn_i | input | 1 | Phase detector down correction |
| boost_en_o | output | 1 | Boost drive enable (0 = high impedance) |
| boost_val_o | output | 1 | Boost drive level when enabled |
| win_no | output | 1 | Lock window, active low |

## Verification
The assertions check the following on every cycle:
- the window opens one cycle after the count match;
- the drive direction follows the correction;
- conflicting corrections leave the output undriven;
- standby forces the drive off and clears the stop latch;
- the stop latch holds while running;
- every stop follows a cycle of open window.

Some behaviours need whole divider frames in sequence, so only the bench scenarios can show them:
- the exact 2*HALF window length;
- that a pulse starting early, or one outlasting the window, leaves the block armed;
- that a later contained pulse disarms it for good;
- that standby brings it back.

// File: rtl/lw_boost_pkg.sv
package lw_boost_pkg;
  localparam int unsigned LW_CNT_W = 16;
  localparam int unsigned LW_HALF  = 32;

  typedef enum logic [1:0] {
    DRV_FLOAT = 2'b00,
    DRV_HIGH  = 2'b01,
    DRV_LOW   = 2'b10
  } drv_e;
endpackage

// File: rtl/lw_window_gen.sv
module lw_window_gen #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned HALF  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fv_i,
  input  logic [CNT_W-1:0] cnt_rem_i,
  output logic             win_no
);
  localparam int unsigned POST_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0]  OPEN_AT  = CNT_W'(HALF);
  localparam logic [POST_W-1:0] POST_TOP = POST_W'(HALF - 1);

  logic              fv_q;
  logic              win_n_q;
  logic              post_act_q;
  logic [POST_W-1:0] post_cnt_q;
  logic              fv_fall;

  assign fv_fall = fv_q & ~fv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fv_q       <= 1'b0;
      win_n_q    <= 1'b1;
      post_act_q <= 1'b0;
      post_cnt_q <= '0;
    end else if (!run_i) begin
      fv_q       <= 1'b0;
      win_n_q    <= 1'b1;
      post_act_q <= 1'b0;
      post_cnt_q <= '0;
    end else begin
      fv_q <= fv_i;
      if (fv_fall) begin
        post_act_q <= 1'b1;
        post_cnt_q <= POST_TOP;
      end else if (post_act_q) begin
        if (post_cnt_q == '0) begin
          post_act_q <= 1'b0;
          win_n_q    <= 1'b1;
        end else begin
          post_cnt_q <= post_cnt_q - 1'b1;
        end
      end
      // opening has priority over a coincident close
      if (cnt_rem_i == OPEN_AT) win_n_q <= 1'b0;
    end
  end

  assign win_no = win_n_q;
endmodule

// File: rtl/lw_pulse_judge.sv
module lw_pulse_judge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic up_i,
  input  logic dn_i,
  input  logic win_ni,
  output logic stopped_o
);
  logic corr, corr_q, rise, fall;
  logic inside_q, stopped_q;

  assign corr = up_i | dn_i;
  assign rise = corr & ~corr_q;
  assign fall = ~corr & corr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corr_q    <= 1'b0;
      inside_q  <= 1'b0;
      stopped_q <= 1'b0;
    end else if (!run_i) begin
      corr_q    <= 1'b0;
      inside_q  <= 1'b0;
      stopped_q <= 1'b0;
    end else begin
      corr_q <= corr;
      if (rise && !win_ni)     inside_q <= 1'b1;
      else if (corr && win_ni) inside_q <= 1'b0;  // started early or outlived window
      if (fall) begin
        inside_q <= 1'b0;
        if (inside_q && !win_ni) stopped_q <= 1'b1;
      end
    end
  end

  assign stopped_o = stopped_q;
endmodule

// File: rtl/lw_boost_drv.sv
module lw_boost_drv
  import lw_boost_pkg::*;
(
  input  logic run_i,
  input  logic stopped_i,
  input  logic up_i,
  input  logic dn_i,
  output logic en_o,
  output logic val_o
);
  drv_e drv;

  always_comb begin
    drv = DRV_FLOAT;
    if (run_i && !stopped_i) begin
      unique case ({up_i, dn_i})
        2'b10:   drv = DRV_HIGH;
        2'b01:   drv = DRV_LOW;
        default: drv = DRV_FLOAT;
      endcase
    end
  end

  assign en_o  = (drv != DRV_FLOAT);
  assign val_o = (drv == DRV_HIGH);
endmodule

// File: rtl/lock_boost_ctrl.sv
module lock_boost_ctrl
  import lw_boost_pkg::*;
#(
  parameter int unsigned CNT_W = LW_CNT_W,
  parameter int unsigned HALF  = LW_HALF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fv_i,
  input  logic [CNT_W-1:0] cnt_rem_i,
  input  logic             up_i,
  input  logic             dn_i,
  output logic             boost_en_o,
  output logic             boost_val_o,
  output logic             win_no
);
  logic win_n;
  logic stopped;

  lw_window_gen #(.CNT_W(CNT_W), .HALF(HALF)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .fv_i      (fv_i),
    .cnt_rem_i (cnt_rem_i),
    .win_no    (win_n)
  );

  lw_pulse_judge u_judge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .up_i      (up_i),
    .dn_i      (dn_i),
    .win_ni    (win_n),
    .stopped_o (stopped)
  );

  lw_boost_drv u_drv (
    .run_i     (run_i),
    .stopped_i (stopped),
    .up_i      (up_i),
    .dn_i      (dn_i),
    .en_o      (boost_en_o),
    .val_o     (boost_val_o)
  );

  assign win_no = win_n;
endmodule

// File: rtl/lock_boost_ctrl_chk.sv
module lock_boost_ctrl_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned HALF  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic [CNT_W-1:0] cnt_rem_i,
  input logic             up_i,
  input logic             dn_i,
  input logic             boost_en_o,
  input logic             boost_val_o,
  input logic             win_no,
  input logic             stopped_i
);
  assert_open_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_rem_i == CNT_W'(HALF)) |=> !win_no);

  assert_up_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boost_en_o && up_i) |-> boost_val_o);

  assert_dn_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boost_en_o && dn_i) |-> !boost_val_o);

  assert_stop_in_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stopped_i) |-> $past(!win_no));

  assert_stop_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped_i && run_i) |=> stopped_i);

  assert_standby_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !boost_en_o);

  assert_standby_rearm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!stopped_i && win_no));

  assert_conflict_float_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && dn_i) |-> !boost_en_o);
endmodule

bind lock_boost_ctrl lock_boost_ctrl_chk #(.CNT_W(CNT_W), .HALF(HALF)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .cnt_rem_i   (cnt_rem_i),
  .up_i        (up_i),
  .dn_i        (dn_i),
  .boost_en_o  (boost_en_o),
  .boost_val_o (boost_val_o),
  .win_no      (win_no),
  .stopped_i   (stopped)
);

// File: tb/lock_boost_ctrl_bench.sv
`timescale 1ns/1ps
module lock_boost_ctrl_bench;
  localparam int CNT_W = 16;
  localparam int HALF  = 32;
  localparam int PER   = 4 * HALF;  // divider period of the model
  localparam int IDLE  = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, fv = 1'b0, up = 1'b0, dn = 1'b0;
  logic [CNT_W-1:0] cnt_rem = CNT_W'(IDLE);
  logic en_o, val_o, win_n;

  int n_tot = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lock_boost_ctrl #(.CNT_W(CNT_W), .HALF(HALF)) u_lock_boost_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .fv_i(fv), .cnt_rem_i(cnt_rem),
    .up_i(up), .dn_i(dn), .boost_en_o(en_o), .boost_val_o(val_o), .win_no(win_n)
  );

  typedef struct packed {
    logic run, up, dn, exp_en, exp_val;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R3 up drives high (R9 armed after reset)
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R4 down drives low
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R10 conflict floats
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R8 standby floats
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0}   // no correction floats
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_tot++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    up = 1'b0; dn = 1'b0; fv = 1'b0; cnt_rem = CNT_W'(IDLE);
  endtask

  // one divider frame; cnt_rem counts PER-1..0, FV falls when it reaches 0
  task automatic frame(input bit prev_open, input int ps, input int pe, input bit pup,
                       input int chk_k, input logic exp_en, input string req);
    int bad_k = -1;
    logic bad_v = 1'b0, bad_e = 1'b0;
    for (int k = 0; k < PER; k++) begin
      int i = PER - 1 - k;
      logic exp_w, c;
      @(negedge clk);
      cnt_rem = CNT_W'(i);
      fv = (i != 0) && (i <= PER / 2);
      c = (k >= ps) && (k <= pe);
      up = c & pup;
      dn = c & ~pup;
      #1;
      exp_w = !((k >= PER - HALF) || (prev_open && k < HALF));
      if (win_n !== exp_w && bad_k < 0) begin
        bad_k = k; bad_v = win_n; bad_e = exp_w;
      end
      if (k == chk_k) begin
        check(req, en_o, exp_en);
        if (exp_en) check(req, val_o, pup);
      end
    end
    n_tot++;
    if (bad_k >= 0) begin
      n_fail++;
      $display("FAIL R1 R2 window at k=%0d actual=%b expected=%b", bad_k, bad_v, bad_e);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_tot++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R9 reset window", win_n, 1'b1);
    check("R9 reset drive", en_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    run = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      run = VECS[v].run; up = VECS[v].up; dn = VECS[v].dn;
      #1;
      check($sformatf("vec%0d R3 R4 R8 R10 en", v), en_o, VECS[v].exp_en);
      if (VECS[v].exp_en) check($sformatf("vec%0d R3 R4 val", v), val_o, VECS[v].exp_val);
      check($sformatf("vec%0d R8 window", v), win_n, 1'b1);
      idle();
      run = 1'b1;
    end

    // R5 early pulse 90..100 straddles opening at 96
    frame(0, 90, 100, 1'b1, 95, 1'b1, "R5 early pulse drives");
    // R6 pulse 20..40 outlives the close at 32; R4 drive low
    frame(1, 20, 40, 1'b0, 25, 1'b1, "R4 R6 straddling pulse drives");
    // still armed after R5 and R6 pulses; contained pulse 100..110 then stops
    frame(1, 100, 110, 1'b1, 100, 1'b1, "R5 R6 armed before contained pulse");
    frame(1, 100, 110, 1'b1, 105, 1'b0, "R6 R7 stopped inside window");
    frame(1, 40, 45, 1'b1, 42, 1'b0, "R7 stopped outside window");

    // R8 standby and re-arm
    @(negedge clk);
    up = 1'b1; dn = 1'b0; cnt_rem = CNT_W'(IDLE); fv = 1'b0; run = 1'b0;
    #1;
    check("R8 standby no drive", en_o, 1'b0);
    @(negedge clk);
    #1;
    check("R8 standby window high", win_n, 1'b1);
    check("R8 standby no drive 2", en_o, 1'b0);
    @(negedge clk);
    run = 1'b1; up = 1'b0;
    @(negedge clk);
    up = 1'b1;
    #1;
    check("R8 rearm drive", en_o, 1'b1);
    check("R8 rearm value", val_o, 1'b1);
    idle();

    done = 1;
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule